// File: doc/BRIEF.md
# Double-Buffered Crossbar Configuration Stage

This block is a four-input, four-output digital crossbar. Every output has its own 4:1 selector, so any input can drive any number of outputs at the same time. The selector of each output is steered by a 3-bit routing code. A code of zero switches that output off, which stands in for a tri-state driver: the data bit is held at 0 and a per-output enable flag is deasserted.

The routing codes are double-buffered. A shadow register is written through a plain write port. A load strobe copies the shadow register into the live configuration register as a whole word, so all four outputs switch on the same clock edge. A pin-select mode bypasses the live register. In that mode two select pins pick one of four fixed routing maps, and the clock to the internal registers is treated as gated off.

A live code outside the legal range switches its output off. It also raises a sticky error flag, which stays set until a load of a fully legal word.

Top module: `xbar_cfg_stage`

## Requirements
- R1: Each routing code selects a source for its output. 3'b000 switches the output off. 3'b001, 3'b010, 3'b011 and 3'b100 select data_i[0], data_i[1], data_i[2] and data_i[3]. An enabled output follows its source combinationally and raises its en_o bit.
- R2: The 12-bit configuration word is laid out with output 1 (data_o[0]) in bits 11:9, output 2 in bits 8:6, output 3 in bits 5:3 and output 4 (data_o[3]) in bits 2:0.
- R3: With mode_i low, a rising edge with load_i high copies the whole shadow word into the live register, and all four outputs take the new routing after that edge. A write to the shadow register does not change the routing by itself. When a write and a load happen on the same edge, the load takes the shadow content from before the write.
- R4: While load_i stays high over several edges, the copy repeats on each edge, so the live register follows every shadow write with one edge of delay.
- R5: With mode_i high, psel_i picks a fixed map and all outputs are enabled. 2'b00 routes data_i[0] to every output. 2'b01 routes data_i[1] to every output. 2'b10 routes data_i[0] to outputs 1 and 2 and data_i[2] to outputs 3 and 4. 2'b11 routes data_i[k] to output k+1.
- R6: With mode_i low, psel_i has no effect on the outputs.
- R7: With mode_i high, shadow writes and load strobes are ignored. After mode_i returns low, the outputs show the routing that was live before, and a later load copies the unchanged shadow word.
- R8: A live code of 3'b101, 3'b110 or 3'b111 switches that output off.
- R9: A load whose word holds an illegal code sets err_o after the edge. err_o then holds until a load whose four codes are all legal clears it. Shadow writes without a load leave err_o unchanged.
- R10: Synchronous reset (rst high at a rising edge) clears the shadow and live registers to zero and clears err_o. All outputs are then off, and a load without a prior write keeps them off.
- R11: An output that is off drives 0 on data_o and 0 on en_o, whatever its inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock; rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | 1 = pin-select preset mode with the registers frozen, 0 = register-driven routing |
| psel_i | input | 2 | Preset map select, used only while mode_i is high |
| wr_i | input | 1 | Shadow register write strobe |
| wdata_i | input | 12 | Word written into the shadow register |
| load_i | input | 1 | Copies the shadow word into the live register on a rising edge |
| data_i | input | 4 | Crossbar data inputs, bit k is input k+1 |
| data_o | output | 4 | Crossbar data outputs, bit k is output k+1 |
| en_o | output | 4 | Per-output enable, 0 when the output is off |
| err_o | output | 1 | Sticky flag: the live word holds an illegal code |

## Verification
The case that is hardest to reach from the ports is a load and a shadow write on the same edge. The same applies to a load strobe held high while the shadow changes underneath it. In both cases the live register must pick up the content from before the write, and the outputs alone cannot tell which version was copied. The stimulus therefore writes a recognisable word, then on one edge writes a different word while loading. The outputs after that edge must show the first word. Holding load high over a run of writes then shows the same one-edge lag. The frozen-register behaviour is reached the same way: writes and loads are issued in preset mode, mode is dropped, and both the live routing and the shadow content are read back through a later load.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;
  localparam int XB_PORTS  = 4;
  localparam int XB_CODE_W = 3;
  localparam int XB_CFG_W  = XB_PORTS * XB_CODE_W;
  localparam int XB_PSEL_W = 2;

  typedef logic [XB_CODE_W-1:0] code_t;
  typedef logic [XB_CFG_W-1:0]  cfg_word_t;

  // legal codes: 0 (off) and 1..XB_PORTS (input index + 1)
  function automatic logic code_ok(code_t c);
    return c <= code_t'(XB_PORTS);
  endfunction

  // one-hot source select; all zero for off or illegal codes
  function automatic logic [XB_PORTS-1:0] code_onehot(code_t c);
    logic [XB_PORTS-1:0] r;
    r = '0;
    for (int i = 0; i < XB_PORTS; i++)
      if (c == code_t'(i + 1)) r[i] = 1'b1;
    return r;
  endfunction

  // output k (0-based) sits in the most significant free field first
  function automatic code_t field_get(cfg_word_t w, int k);
    return w[(XB_PORTS-1-k)*XB_CODE_W +: XB_CODE_W];
  endfunction

  function automatic logic word_has_bad(cfg_word_t w);
    logic bad;
    bad = 1'b0;
    for (int k = 0; k < XB_PORTS; k++)
      if (!code_ok(field_get(w, k))) bad = 1'b1;
    return bad;
  endfunction

  // fixed maps chosen by the select pins
  function automatic cfg_word_t preset_word(logic [XB_PSEL_W-1:0] s);
    cfg_word_t w;
    code_t     c;
    w = '0;
    for (int k = 0; k < XB_PORTS; k++) begin
      case (s)
        2'b00:   c = code_t'(1);
        2'b01:   c = code_t'(2);
        2'b10:   c = (k < XB_PORTS/2) ? code_t'(1) : code_t'(3);
        default: c = code_t'(k + 1);
      endcase
      w[(XB_PORTS-1-k)*XB_CODE_W +: XB_CODE_W] = c;
    end
    return w;
  endfunction
endpackage

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs
  import xbar_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      mode_i,
  input  logic      wr_i,
  input  cfg_word_t wdata_i,
  input  logic      load_i,
  output cfg_word_t cfg_o,
  output logic      err_o
);
  cfg_word_t shadow_q;
  cfg_word_t cfg_q;
  logic      err_q;

  // preset mode stands for a gated-off control clock
  logic clk_live;
  logic load_fire;
  logic wr_fire;

  assign clk_live  = !mode_i;
  assign load_fire = clk_live & load_i;
  assign wr_fire   = clk_live & wr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      cfg_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      if (load_fire) begin
        cfg_q <= shadow_q;
        err_q <= word_has_bad(shadow_q);
      end
      if (wr_fire) shadow_q <= wdata_i;
    end
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;

  // R3 / R4: each effective load captures the pre-edge shadow word
  p_load_copies_r3: assert property (@(posedge clk) disable iff (rst)
    load_fire |=> cfg_q == $past(shadow_q));

  // R3: without a load the live word does not move
  p_cfg_holds_r3: assert property (@(posedge clk) disable iff (rst)
    !load_fire |=> $stable(cfg_q));

  // R7: preset mode freezes every register
  p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    mode_i |=> ($stable(shadow_q) && $stable(cfg_q) && $stable(err_q)));

  // R9: flag only moves on a load and always mirrors the live word
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    !load_fire |=> $stable(err_q));
  p_err_matches_r9: assert property (@(posedge clk) disable iff (rst)
    err_q == word_has_bad(cfg_q));
endmodule

// File: rtl/xbar_preset_dec.sv
module xbar_preset_dec
  import xbar_cfg_pkg::*;
(
  input  logic                 mode_i,
  input  logic [XB_PSEL_W-1:0] psel_i,
  input  cfg_word_t            cfg_i,
  output cfg_word_t            active_o
);
  cfg_word_t preset_w;

  always_comb begin
    preset_w = preset_word(psel_i);
    active_o = mode_i ? preset_w : cfg_i;
  end
endmodule

// File: rtl/xbar_lane.sv
module xbar_lane
  import xbar_cfg_pkg::*;
(
  input  code_t               code_i,
  input  logic [XB_PORTS-1:0] data_i,
  output logic                q_o,
  output logic                en_o,
  output logic                bad_o
);
  logic [XB_PORTS-1:0] sel;

  always_comb begin
    sel   = code_onehot(code_i);
    en_o  = |sel;
    q_o   = |(sel & data_i);
    bad_o = !code_ok(code_i);
  end
endmodule

// File: rtl/xbar_cfg_stage.sv
module xbar_cfg_stage
  import xbar_cfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_i,
  input  logic [XB_PSEL_W-1:0] psel_i,
  input  logic                 wr_i,
  input  logic [XB_CFG_W-1:0]  wdata_i,
  input  logic                 load_i,
  input  logic [XB_PORTS-1:0]  data_i,
  output logic [XB_PORTS-1:0]  data_o,
  output logic [XB_PORTS-1:0]  en_o,
  output logic                 err_o
);
  cfg_word_t           live_cfg;
  cfg_word_t           active_cfg;
  logic [XB_PORTS-1:0] lane_bad;

  xbar_cfg_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .mode_i  (mode_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .load_i  (load_i),
    .cfg_o   (live_cfg),
    .err_o   (err_o)
  );

  xbar_preset_dec u_preset (
    .mode_i   (mode_i),
    .psel_i   (psel_i),
    .cfg_i    (live_cfg),
    .active_o (active_cfg)
  );

  for (genvar k = 0; k < XB_PORTS; k++) begin : g_lane
    code_t lane_code;
    assign lane_code = field_get(active_cfg, k);

    xbar_lane u_lane (
      .code_i (lane_code),
      .data_i (data_i),
      .q_o    (data_o[k]),
      .en_o   (en_o[k]),
      .bad_o  (lane_bad[k])
    );
  end

  // R5: every preset map enables all outputs
  p_preset_all_on_r5: assert property (@(posedge clk) disable iff (rst)
    mode_i |-> (&en_o));

  // R8: a lane reporting an illegal code is off
  p_bad_is_off_r8: assert property (@(posedge clk) disable iff (rst)
    (lane_bad != '0) |-> ((lane_bad & en_o) == '0));

  // R11: an off output never drives a one
  p_off_drives_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (data_o & ~en_o) == '0);
endmodule

// File: tb/xbar_cfg_stage_tb.sv
module xbar_cfg_stage_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        mode_i;
  logic [1:0]  psel_i;
  logic        wr_i;
  logic [11:0] wdata_i;
  logic        load_i;
  logic [3:0]  data_i;
  logic [3:0]  data_o;
  logic [3:0]  en_o;
  logic        err_o;

  always #5 clk = ~clk;

  xbar_cfg_stage u_dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .psel_i(psel_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .load_i(load_i),
    .data_i(data_i), .data_o(data_o), .en_o(en_o), .err_o(err_o)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  // bench model state
  logic [11:0] m_sh  = '0;
  logic [11:0] m_cfg = '0;
  logic        m_err = 1'b0;

  function automatic logic word_bad(logic [11:0] w);
    return (w[11:9] > 3'd4) || (w[8:6] > 3'd4) || (w[5:3] > 3'd4) || (w[2:0] > 3'd4);
  endfunction

  // expected {err, en[3:0], data[3:0]}
  function automatic logic [8:0] predict(logic m, logic [1:0] ps, logic [11:0] cfg,
                                         logic [3:0] din, logic err);
    logic [11:0] w;
    logic [3:0]  d;
    logic [3:0]  e;
    if (m) begin
      case (ps)
        2'b00:   w = 12'o1111;
        2'b01:   w = 12'o2222;
        2'b10:   w = 12'o1133;
        default: w = 12'o1234;
      endcase
    end else begin
      w = cfg;
    end
    for (int o = 0; o < 4; o++) begin
      logic [2:0] c;
      c = w[11-3*o -: 3];
      case (c)
        3'd1:    begin d[o] = din[0]; e[o] = 1'b1; end
        3'd2:    begin d[o] = din[1]; e[o] = 1'b1; end
        3'd3:    begin d[o] = din[2]; e[o] = 1'b1; end
        3'd4:    begin d[o] = din[3]; e[o] = 1'b1; end
        default: begin d[o] = 1'b0;   e[o] = 1'b0; end
      endcase
    end
    return {err, e, d};
  endfunction

  // driver: one vector per cycle, expectation for after the next rising edge
  task automatic step(input logic r, input logic m, input logic [1:0] ps,
                      input logic w, input logic [11:0] wd, input logic ld,
                      input logic [3:0] din, input string tag);
    @(negedge clk);
    rst = r; mode_i = m; psel_i = ps; wr_i = w; wdata_i = wd;
    load_i = ld; data_i = din;
    if (r) begin
      m_sh = '0; m_cfg = '0; m_err = 1'b0;
    end else if (!m) begin
      if (ld) begin
        m_cfg = m_sh;
        m_err = word_bad(m_sh);
      end
      if (w) m_sh = wd;
    end
    exp_q.push_back(predict(m, ps, m_cfg, din, m_err));
    tag_q.push_back(tag);
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [8:0] exp_v;
        logic [8:0] act_v;
        string      t;
        exp_v = exp_q.pop_front();
        t     = tag_q.pop_front();
        act_v = {err_o, en_o, data_o};
        vectors++;
        if (act_v !== exp_v) begin
          miscompares++;
          $display("FAIL %s: actual err=%b en=%b data=%b expected err=%b en=%b data=%b",
                   t, act_v[8], act_v[7:4], act_v[3:0], exp_v[8], exp_v[7:4], exp_v[3:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mode_i = 1'b0; psel_i = 2'b00; wr_i = 1'b0;
    wdata_i = '0; load_i = 1'b0; data_i = 4'hF;

    // R10 reset state, load with empty shadow
    step(1, 0, 2'b00, 0, 12'o0000, 0, 4'hF, "R10");
    step(1, 0, 2'b00, 0, 12'o0000, 0, 4'hF, "R10");
    step(0, 0, 2'b00, 0, 12'o0000, 1, 4'hF, "R10");

    // R3 shadow write alone does not route; load does
    step(0, 0, 2'b00, 1, 12'o1234, 0, 4'hF, "R3");
    step(0, 0, 2'b00, 0, 12'o0000, 1, 4'b0101, "R3");

    // R1 straight routing under every data pattern
    for (int i = 0; i < 16; i++)
      step(0, 0, 2'b00, 0, 12'o0000, 0, 4'(i), "R1");

    // R2 reversed field layout
    step(0, 0, 2'b00, 1, 12'o4321, 0, 4'b0001, "R2");
    step(0, 0, 2'b00, 0, 12'o0000, 1, 4'b0001, "R2");
    step(0, 0, 2'b00, 0, 12'o0000, 0, 4'b1000, "R2");
    step(0, 0, 2'b00, 1, 12'o3141, 1, 4'b0110, "R2");
    step(0, 0, 2'b00, 0, 12'o0000, 1, 4'b0110, "R2");

    // R3 write and load on the same edge: old shadow is taken
    step(0, 0, 2'b00, 1, 12'o4321, 0, 4'hF, "R3");
    step(0, 0, 2'b00, 1, 12'o0000, 1, 4'b1010, "R3");

    // R4 load held high across writes
    step(0, 0, 2'b00, 1, 12'o2222, 1, 4'b0010, "R4");
    step(0, 0, 2'b00, 1, 12'o3333, 1, 4'b0010, "R4");
    step(0, 0, 2'b00, 0, 12'o0000, 1, 4'b0100, "R4");
    step(0, 0, 2'b00, 0, 12'o0000, 1, 4'b0100, "R4");

    // R11 off codes on some outputs
    step(0, 0, 2'b00, 1, 12'o1020, 1, 4'hF, "R11");
    step(0, 0, 2'b00, 0, 12'o0000, 1, 4'hF, "R11");
    step(0, 0, 2'b00, 0, 12'o0000, 0, 4'h0, "R11");

    // R8 / R9 illegal codes and the sticky flag
    step(0, 0, 2'b00, 1, 12'o5170, 0, 4'hF, "R9");
    step(0, 0, 2'b00, 0, 12'o0000, 1, 4'hF, "R8");
    step(0, 0, 2'b00, 0, 12'o0000, 0, 4'hF, "R9");
    step(0, 0, 2'b00, 1, 12'o6666, 0, 4'hF, "R9");
    step(0, 0, 2'b00, 1, 12'o1111, 0, 4'hF, "R9");
    step(0, 0, 2'b00, 0, 12'o0000, 1, 4'hE, "R9");
    step(0, 0, 2'b00, 1, 12'o0007, 1, 4'hF, "R8");
    step(0, 0, 2'b00, 0, 12'o0000, 1, 4'hF, "R8");

    // R5 preset maps
    for (int p = 0; p < 4; p++) begin
      step(0, 1, 2'(p), 0, 12'o0000, 0, 4'b0101, "R5");
      step(0, 1, 2'(p), 0, 12'o0000, 0, 4'b1010, "R5");
      step(0, 1, 2'(p), 0, 12'o0000, 0, 4'b0011, "R5");
      step(0, 1, 2'(p), 0, 12'o0000, 0, 4'b1100, "R5");
    end

    // R7 frozen registers while in preset mode
    step(0, 0, 2'b00, 1, 12'o1111, 1, 4'hF, "R7");
    step(0, 0, 2'b00, 0, 12'o0000, 1, 4'b0001, "R7");
    step(0, 1, 2'b11, 1, 12'o4444, 1, 4'b1000, "R7");
    step(0, 1, 2'b10, 1, 12'o5555, 1, 4'b1000, "R7");
    step(0, 0, 2'b11, 0, 12'o0000, 0, 4'b0001, "R7");
    step(0, 0, 2'b11, 0, 12'o0000, 1, 4'b1000, "R7");

    // R6 select pins ignored when mode is low
    for (int p = 0; p < 4; p++)
      step(0, 0, 2'(p), 0, 12'o0000, 0, 4'b0001, "R6");

    // R10 reset mid-run clears routing, shadow and flag
    step(0, 0, 2'b00, 1, 12'o7777, 1, 4'hF, "R10");
    step(0, 0, 2'b00, 0, 12'o0000, 1, 4'hF, "R10");
    step(1, 0, 2'b00, 0, 12'o0000, 0, 4'hF, "R10");
    step(0, 0, 2'b00, 0, 12'o0000, 1, 4'hF, "R10");

    step(0, 0, 2'b00, 0, 12'o0000, 0, 4'hF, "R10");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule